// File: doc/BRIEF.md
# Write-Only I2C Register Target

This block is a receive-only target on a two-wire I2C bus. A bus master addresses it, sends one byte, and the block hands that byte to the surrounding logic on a parallel output together with a single-cycle valid strobe. Both bus lines are oversampled by a fast system clock, so the block needs no clock of its own from the bus. The only signal it drives back is an open-drain pull-down enable for SDA, used solely for acknowledge bits.

The 7-bit target address is fixed in its upper six bits to `111110`. Its lowest bit comes from a strap pin, so two of these blocks can share one bus. Only write transfers to that address are accepted. Reads, foreign addresses and any bytes past the first are left unacknowledged. A START restarts address reception at any time. A STOP returns the block to idle at any time.

Top module: `wo_i2c_target`

## Requirements
- R1: After reset, `sda_pull` is 0, `byte_stb` is 0 and `byte_out` is 0.
- R2: An address frame is 7 address bits sent MSB first, followed by a direction bit (0 = write). When the address equals `{111110, addr_lsb}` and the direction bit is 0, the block pulls SDA low during the ninth SCL clock.
- R3: When the received address differs from `{111110, addr_lsb}`, SDA is never pulled low and no strobe is raised until the next START or STOP.
- R4: A frame with the matching address and the direction bit set to 1 is not acknowledged, and no later byte in that transaction is acknowledged or delivered.
- R5: The data byte that follows an acknowledged address is received MSB first and is acknowledged. `byte_out` takes its value and `byte_stb` is high for exactly one system clock, in the cycle the data ACK drive begins and before any STOP.
- R6: The SDA pull-down turns on only after an SCL falling edge, the one that ends the eighth bit of a frame. It is off again after the SCL falling edge that ends the ninth bit. It is never on while the master is sending bits 1 to 8.
- R7: In one transaction, a second data byte and any later bytes get no ACK, raise no strobe and leave `byte_out` unchanged.
- R8: A STOP in the middle of a byte drops the partial byte: no strobe, SDA released, and `byte_out` unchanged. The next transaction is received normally.
- R9: A repeated START after any number of bits restarts address reception from the first address bit.
- R10: `byte_out` changes only in a cycle where `byte_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired level) |
| addr_lsb | input | 1 | Strap selecting the lowest address bit |
| sda_pull | output | 1 | 1 = drive SDA low, 0 = release the line |
| byte_out | output | 8 | Last accepted data byte |
| byte_stb | output | 1 | One-cycle pulse when a new byte is accepted |

## Verification
The hardest states to reach from the pins are the aborted and the restarted transactions. In one, a STOP or repeated START lands after an accepted address but in the middle of the data shift. In the other, extra bytes arrive after the data ACK. The bench models the master at the bit level, so it can cut a transaction after any number of SCL clocks. It does this in directed cases, and then checks that the next full write is still accepted. Random transactions mix matching and foreign addresses, both directions and both strap values, and add trailing bytes to them.

// File: rtl/wo_i2c_pkg.sv
package wo_i2c_pkg;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_ADDR,
      TS_ADDR_ACK,
      TS_DATA,
      TS_DATA_ACK,
      TS_PASSIVE
   } tgt_state_e;

endpackage

// File: rtl/wo_i2c_line_sync.sv
module wo_i2c_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              level_d;

   // idle bus level is high, so every stage resets to 1
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= pin;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= chain[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) level_d <= 1'b1;
      else        level_d <= chain[STAGES-1];

   assign level = chain[STAGES-1];
   assign rise  = level & ~level_d;
   assign fall  = ~level & level_d;
endmodule

// File: rtl/wo_i2c_engine.sv
module wo_i2c_engine
   import wo_i2c_pkg::*;
#(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned DATA_W  = 8,
   parameter logic [ADDR_W-2:0] ADDR_HI = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              start_hit,
   input  logic              stop_hit,
   input  logic              addr_lsb,
   output logic              sda_pull,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_stb
);
   localparam int unsigned FRAME_W = ADDR_W + 1;
   localparam int unsigned SH_W    = (DATA_W > FRAME_W) ? DATA_W : FRAME_W;
   localparam int unsigned CNT_W   = $clog2(SH_W + 1);
   localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] DATA_CNT  = CNT_W'(DATA_W);

   tgt_state_e        state;
   logic [SH_W-1:0]   shreg;
   logic [CNT_W-1:0]  nbits;
   logic [ADDR_W-1:0] own_addr;
   logic              addr_ok;

   assign own_addr = {ADDR_HI, addr_lsb};
   // shreg[0] holds the direction bit once a full frame is in
   assign addr_ok  = (shreg[FRAME_W-1:1] == own_addr) && !shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TS_IDLE;
         shreg    <= '0;
         nbits    <= '0;
         sda_pull <= 1'b0;
         byte_out <= '0;
         byte_stb <= 1'b0;
      end else begin
         byte_stb <= 1'b0;
         if (stop_hit) begin
            state    <= TS_IDLE;
            sda_pull <= 1'b0;
         end else if (start_hit) begin
            state    <= TS_ADDR;
            nbits    <= '0;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               TS_ADDR: begin
                  if (scl_rise && nbits < FRAME_CNT) begin
                     shreg <= {shreg[SH_W-2:0], sda_lvl};
                     nbits <= nbits + 1'b1;
                  end else if (scl_fall && nbits == FRAME_CNT) begin
                     if (addr_ok) begin
                        sda_pull <= 1'b1;
                        state    <= TS_ADDR_ACK;
                     end else begin
                        state    <= TS_PASSIVE;
                     end
                  end
               end
               TS_ADDR_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     nbits    <= '0;
                     state    <= TS_DATA;
                  end
               end
               TS_DATA: begin
                  if (scl_rise && nbits < DATA_CNT) begin
                     shreg <= {shreg[SH_W-2:0], sda_lvl};
                     nbits <= nbits + 1'b1;
                  end else if (scl_fall && nbits == DATA_CNT) begin
                     sda_pull <= 1'b1;
                     byte_out <= shreg[DATA_W-1:0];
                     byte_stb <= 1'b1;
                     state    <= TS_DATA_ACK;
                  end
               end
               TS_DATA_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     state    <= TS_PASSIVE;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/wo_i2c_target.sv
module wo_i2c_target #(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [ADDR_W-2:0] ADDR_HI = 6'b111110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              addr_lsb,
   output logic              sda_pull,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_stb
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("ADDR_W and DATA_W must be at least 2");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic start_hit, stop_hit;

   wo_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .pin(scl_in),
      .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
   );

   wo_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .pin(sda_in),
      .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
   );

   // bus conditions: SDA moving while SCL is held high
   assign start_hit = sda_fall & scl_lvl;
   assign stop_hit  = sda_rise & scl_lvl;

   wo_i2c_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_HI(ADDR_HI)
   ) u_engine (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
      .start_hit(start_hit), .stop_hit(stop_hit), .addr_lsb(addr_lsb),
      .sda_pull(sda_pull), .byte_out(byte_out), .byte_stb(byte_stb)
   );
endmodule

// File: rtl/wo_i2c_target_chk.sv
module wo_i2c_target_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sda_pull,
   input logic          byte_stb,
   input logic [DW-1:0] byte_out,
   input logic          scl_lvl,
   input logic          stop_hit
);
   // R5
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |=> !byte_stb);

   // R5
   stb_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |-> sda_pull);

   // R6
   pull_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_lvl);

   // R8
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_hit |=> !sda_pull);

   // R10
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(byte_out) |-> byte_stb);
endmodule

bind wo_i2c_target wo_i2c_target_chk #(.DW(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .byte_stb(byte_stb),
   .byte_out(byte_out), .scl_lvl(scl_lvl), .stop_hit(stop_hit)
);

// File: tb/test_wo_i2c_target.sv
module test_wo_i2c_target;
   localparam int Q = 5;   // system clocks per quarter SCL period (SCL = clk/20)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       addr_lsb = 1'b0;
   logic       sda_pull;
   logic [7:0] byte_out;
   logic       byte_stb;
   wire        sda_line = sda_m & ~sda_pull;

   int total = 0;
   int bad = 0;
   int strobes = 0;
   logic [7:0] last_seen = '0;
   logic [7:0] exp_hold = '0;
   bit finished = 0;

   always #4 clk = ~clk;

   wo_i2c_target i_wo_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .addr_lsb(addr_lsb), .sda_pull(sda_pull), .byte_out(byte_out),
      .byte_stb(byte_stb)
   );

   always @(negedge clk)
      if (rst_n && byte_stb) begin
         strobes++;
         last_seen = byte_out;
      end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_ack(input logic [6:0] a, input bit rw, input logic sel);
      return (a == {6'b111110, sel}) && !rw;
   endfunction

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
   endtask

   task automatic bus_bit(input logic b, input bit is_ack, output logic seen);
      sda_m = is_ack ? 1'b1 : b;
      qwait(); scl_m = 1'b1; qwait();
      seen = sda_line;
      if (!is_ack) check("R6 pull off during master bit", sda_pull, 0);
      qwait(); scl_m = 1'b0; qwait();
   endtask

   task automatic bus_byte(input logic [7:0] v, output bit acked);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(v[i], 1'b0, s);
      bus_bit(1'b1, 1'b1, s);
      acked = !s;
   endtask

   task automatic do_xfer(input logic [6:0] a, input bit rw, input logic [7:0] d, input int extra);
      bit m, ack;
      int s0;
      string tag;
      m  = exp_ack(a, rw, addr_lsb);
      s0 = strobes;
      tag = m ? "R2" : ((a == {6'b111110, addr_lsb}) ? "R4" : "R3");
      bus_start();
      bus_byte({a, rw}, ack);
      check({tag, " address ack"}, ack, m);
      bus_byte(d, ack);
      check(m ? "R5 data ack" : {tag, " data ack"}, ack, m);
      for (int k = 0; k < extra; k++) begin
         bus_byte(d ^ 8'h5a, ack);
         check("R7 extra byte nack", ack, 0);
      end
      check(m ? "R5 strobe before stop" : {tag, " no strobe"}, strobes - s0, m);
      bus_stop();
      qwait();
      if (m) exp_hold = d;
      check("R7 strobe count", strobes - s0, m);
      check("R10 byte_out value", byte_out, exp_hold);
      if (m) check("R5 strobed data", last_seen, d);
      check("R6 pull off after transfer", sda_pull, 0);
   endtask

   initial begin
      bit ack;
      logic s;
      int s0;
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      check("R1 sda_pull reset", sda_pull, 0);
      check("R1 byte_stb reset", byte_stb, 0);
      check("R1 byte_out reset", byte_out, 0);
      rst_n = 1'b1;
      qwait();

      // R2 both strap values
      addr_lsb = 1'b0; do_xfer(7'b1111100, 1'b0, 8'hA5, 0);
      addr_lsb = 1'b1; do_xfer(7'b1111101, 1'b0, 8'h3C, 0);
      // R3 other strap address and a foreign address
      do_xfer(7'b1111100, 1'b0, 8'h11, 0);
      do_xfer(7'b0101010, 1'b0, 8'h22, 1);
      // R4 read at own address
      do_xfer(7'b1111101, 1'b1, 8'h33, 1);
      // R7 trailing bytes
      do_xfer(7'b1111101, 1'b0, 8'hC3, 2);

      // R8 STOP in the middle of the data byte
      s0 = strobes;
      bus_start();
      bus_byte(8'b11111010, ack);
      check("R8 address ack before abort", ack, 1);
      for (int i = 0; i < 4; i++) bus_bit(1'b0, 1'b0, s);
      bus_stop(); qwait();
      check("R8 no strobe on abort", strobes - s0, 0);
      check("R8 pull off on abort", sda_pull, 0);
      check("R8 byte_out unchanged", byte_out, exp_hold);
      do_xfer(7'b1111101, 1'b0, 8'h96, 0);

      // R9 repeated START after partial address, then after partial data
      s0 = strobes;
      bus_start();
      for (int i = 0; i < 3; i++) bus_bit(1'b1, 1'b0, s);
      bus_start();
      bus_byte(8'b11111010, ack);
      check("R9 ack after restart in address", ack, 1);
      for (int i = 0; i < 5; i++) bus_bit(1'b1, 1'b0, s);
      bus_start();
      bus_byte(8'b11111010, ack);
      check("R9 ack after restart in data", ack, 1);
      bus_byte(8'h4E, ack);
      check("R9 data ack", ack, 1);
      bus_stop(); qwait();
      exp_hold = 8'h4E;
      check("R9 single strobe", strobes - s0, 1);
      check("R9 data value", byte_out, 8'h4E);

      // random mix
      for (int n = 0; n < 40; n++) begin
         logic [6:0] a;
         addr_lsb = 1'($urandom);
         a = ($urandom % 2) ? {6'b111110, 1'($urandom)} : 7'($urandom);
         do_xfer(a, ($urandom % 4) == 0, 8'($urandom), int'($urandom % 2));
      end

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule